// File: doc/BRIEF.md
# DRAM ECC Error Log Register File

This block sits beside a memory controller's datapath and records DRAM fault events for software. Five event sources pulse into it for one cycle each: a corrected single-bit ECC error, an uncorrectable multi-bit ECC error, a refresh timeout, a locked access aimed at non-DRAM space, and a thermal sensor trip. Each event sets a sticky flag in a 16-bit status register. An ECC event also presents the failing address (bits 32:7 of a 33-bit physical address, so the log resolves 128-byte lines), the channel it came from and the ECC syndrome. The block latches these details according to a severity rule, so that the worst error seen is the one whose location software finds.

A small state machine tracks what the log currently holds. It has three states: LOG_NONE (no ECC flag set), LOG_CE (the correctable flag is set and the uncorrectable flag is clear) and LOG_UE (the uncorrectable flag is set). Its transitions are: NONE to CE when a correctable error arrives alone, and NONE to UE when an uncorrectable error arrives. CE to UE is the overwrite case, in which an uncorrectable error replaces the logged details. CE to NONE happens when software clears the correctable flag. UE to CE happens when software clears the uncorrectable flag while the correctable flag stays set. UE to NONE happens when both flags end up clear. Every other case stays in the current state. Details are loaded only on NONE to CE, NONE to UE and CE to UE.

Software reaches the registers through a plain port with a combinational read and a one-cycle write. The status flags are cleared by writing ones. A command register picks which flagged sources drive the registered, active-high system error output.

Top module: `errlog_top`

## Requirements
- R1: Status sits at offset 0 with flags at fixed bit positions: bit 0 correctable ECC, bit 1 uncorrectable ECC, bit 8 refresh timeout, bit 9 non-DRAM lock, bit 11 thermal. The error mask is 0x0B03. All other status bits, and offsets 5 to 7, read as zero.
- R2: Writing a 1 to a status bit clears that flag; writing a 0 leaves it unchanged.
- R3: If an event and a clear of its flag occur in the same cycle, the flag ends up set.
- R4: The pointer at offset 2 reads failing address bits 31:7 in bits 31:7, zeros in bits 6:1, and the channel in bit 0.
- R5: The register at offset 3 holds address bit 32 in bit 0; bits 7:1 and above read zero.
- R6: The register at offset 4 holds the 8-bit syndrome of the logged error in bits 7:0.
- R7: A correctable error loads address, channel and syndrome only when neither ECC flag is set.
- R8: An uncorrectable error loads address, channel and syndrome unless the uncorrectable flag is already set. When it replaces an earlier correctable log, the correctable flag stays set.
- R9: When correctable and uncorrectable errors arrive in the same cycle, both flags set and the uncorrectable details are logged.
- R10: The command register at offset 1 keeps only the mask bits 0x0B03 of a write; its other bits read zero.
- R11: The system error output is high exactly one cycle after any status bit and its command bit are both set.
- R12: Writes to offsets 2, 3 and 4 have no effect.
- R13: After reset, every register reads zero and the system error output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_ce | input | 1 | Correctable ECC error pulse |
| ev_ue | input | 1 | Uncorrectable ECC error pulse |
| ev_refto | input | 1 | Refresh timeout pulse |
| ev_lock | input | 1 | Locked access to non-DRAM memory pulse |
| ev_therm | input | 1 | Thermal sensor event pulse |
| ecc_addr | input | 26 | Failing address bits 32:7, valid with an ECC pulse |
| ecc_chan | input | 1 | Failing channel, valid with an ECC pulse |
| ecc_syn | input | SYN_W (8) | ECC syndrome, valid with an ECC pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| serr | output | 1 | System error, registered, active high |

## Verification
The properties assume that the event inputs are single-cycle pulses sampled at the clock edge. They also assume that the address, channel and syndrome inputs are stable in any cycle in which an ECC pulse is high, and that software writes offsets only through wr_en. The bench drives every input just after the falling edge and holds it for exactly one clock, so each pulse and write lands on a single rising edge. It returns the inputs to idle before the next step. The only cases in which two inputs coincide are the ones that deliberately test same-cycle ordering: an event together with its own clear, and both ECC errors together.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    // physical address width and the log line size exponent
    localparam int PA_W      = 33;
    localparam int GRAIN_LSB = 7;
    localparam int LOG_AW    = PA_W - GRAIN_LSB;

    // register port geometry
    localparam int REG_AW = 3;
    localparam int DW     = 32;
    localparam int ST_W   = 16;

    // status / command bit positions (software decodes these)
    localparam int BIT_CE  = 0;
    localparam int BIT_UE  = 1;
    localparam int BIT_RTO = 8;
    localparam int BIT_LCK = 9;
    localparam int BIT_THM = 11;

    localparam logic [ST_W-1:0] ERR_MASK =
        ST_W'((1 << BIT_CE) | (1 << BIT_UE) | (1 << BIT_RTO) |
              (1 << BIT_LCK) | (1 << BIT_THM));

    typedef enum logic [1:0] {
        LOG_NONE = 2'd0,
        LOG_CE   = 2'd1,
        LOG_UE   = 2'd2
    } log_state_t;

    typedef enum logic [REG_AW-1:0] {
        OFS_STS = 3'd0,
        OFS_CMD = 3'd1,
        OFS_PTR = 3'd2,
        OFS_EXT = 3'd3,
        OFS_SYN = 3'd4
    } reg_ofs_t;

endpackage

// File: rtl/errlog_status.sv
module errlog_status
    import errlog_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_vec,
    input  logic [ST_W-1:0] clr_vec,
    output logic [ST_W-1:0] status_q
);

    for (genvar i = 0; i < ST_W; i++) begin : g_bit
        if (ERR_MASK[i]) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    status_q[i] <= 1'b0;
                end else begin
                    // a new event outranks a clear in the same cycle
                    status_q[i] <= set_vec[i] | (status_q[i] & ~clr_vec[i]);
                end
            end
        end else begin : g_rsvd
            assign status_q[i] = 1'b0;
        end
    end

    logic rsvd_unused;
    assign rsvd_unused = ^((set_vec | clr_vec) & ~ERR_MASK);

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
    import errlog_pkg::*;
#(
    parameter int AW    = LOG_AW,
    parameter int SYN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_ce,
    input  logic             ev_ue,
    input  logic             ce_flag,
    input  logic             clr_ce,
    input  logic             clr_ue,
    input  logic [AW-1:0]    ecc_addr,
    input  logic             ecc_chan,
    input  logic [SYN_W-1:0] ecc_syn,
    output log_state_t       state_q,
    output logic [AW-1:0]    addr_q,
    output logic             chan_q,
    output logic [SYN_W-1:0] syn_q
);

    log_state_t state_d;
    logic       ce_kept;
    logic       load;

    // correctable flag still set after this cycle's clear and events
    assign ce_kept = ev_ce | (ce_flag & ~clr_ce);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LOG_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOG_NONE: begin
                if (ev_ue) begin
                    state_d = LOG_UE;
                end else if (ev_ce) begin
                    state_d = LOG_CE;
                end
            end
            LOG_CE: begin
                if (ev_ue) begin
                    state_d = LOG_UE;
                end else if (!ce_kept) begin
                    state_d = LOG_NONE;
                end
            end
            LOG_UE: begin
                if (clr_ue && !ev_ue) begin
                    state_d = ce_kept ? LOG_CE : LOG_NONE;
                end
            end
            default: state_d = LOG_NONE;
        endcase
    end

    // outputs: load the detail registers on the capturing transitions
    always_comb begin
        load = 1'b0;
        unique case (state_q)
            LOG_NONE: load = ev_ue | ev_ce;
            LOG_CE:   load = ev_ue;
            LOG_UE:   load = 1'b0;
            default:  load = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            chan_q <= 1'b0;
            syn_q  <= '0;
        end else if (load) begin
            addr_q <= ecc_addr;
            chan_q <= ecc_chan;
            syn_q  <= ecc_syn;
        end
    end

endmodule

// File: rtl/errlog_regport.sv
module errlog_regport
    import errlog_pkg::*;
#(
    parameter int AW    = LOG_AW,
    parameter int SYN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [ST_W-1:0]   wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    input  logic [ST_W-1:0]   status,
    input  logic [AW-1:0]     log_addr,
    input  logic              log_chan,
    input  logic [SYN_W-1:0]  log_syn,
    output logic [ST_W-1:0]   cmd_q,
    output logic [ST_W-1:0]   clr_vec,
    output logic [DW-1:0]     rd_data
);

    localparam int PTR_HI_W = AW - 1;
    localparam int PAD_W    = GRAIN_LSB - 1;

    logic wr_sts;
    logic wr_cmd;
    logic [DW-1:0] ptr_word;
    logic [DW-1:0] ext_word;

    assign wr_sts  = wr_en && (wr_addr == OFS_STS);
    assign wr_cmd  = wr_en && (wr_addr == OFS_CMD);
    assign clr_vec = wr_sts ? (wr_data & ERR_MASK) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_cmd) begin
            cmd_q <= wr_data & ERR_MASK;
        end
    end

    assign ptr_word = {log_addr[PTR_HI_W-1:0], {PAD_W{1'b0}}, log_chan};
    assign ext_word = {{(DW-1){1'b0}}, log_addr[AW-1]};

    always_comb begin
        case (reg_ofs_t'(rd_addr))
            OFS_STS: rd_data = {{(DW-ST_W){1'b0}}, status};
            OFS_CMD: rd_data = {{(DW-ST_W){1'b0}}, cmd_q};
            OFS_PTR: rd_data = ptr_word;
            OFS_EXT: rd_data = ext_word;
            OFS_SYN: rd_data = {{(DW-SYN_W){1'b0}}, log_syn};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/errlog_top.sv
module errlog_top
    import errlog_pkg::*;
#(
    parameter int SYN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic              ev_refto,
    input  logic              ev_lock,
    input  logic              ev_therm,
    input  logic [LOG_AW-1:0] ecc_addr,
    input  logic              ecc_chan,
    input  logic [SYN_W-1:0]  ecc_syn,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [ST_W-1:0]   wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DW-1:0]     rd_data,
    output logic              serr
);

    logic [ST_W-1:0]   set_vec;
    logic [ST_W-1:0]   clr_vec;
    logic [ST_W-1:0]   status_q;
    logic [ST_W-1:0]   cmd_q;
    log_state_t        log_state;
    logic [LOG_AW-1:0] log_addr;
    logic              log_chan;
    logic [SYN_W-1:0]  log_syn;

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_CE]  = ev_ce;
        set_vec[BIT_UE]  = ev_ue;
        set_vec[BIT_RTO] = ev_refto;
        set_vec[BIT_LCK] = ev_lock;
        set_vec[BIT_THM] = ev_therm;
    end

    errlog_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .status_q (status_q)
    );

    errlog_capture #(.AW(LOG_AW), .SYN_W(SYN_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_ce    (ev_ce),
        .ev_ue    (ev_ue),
        .ce_flag  (status_q[BIT_CE]),
        .clr_ce   (clr_vec[BIT_CE]),
        .clr_ue   (clr_vec[BIT_UE]),
        .ecc_addr (ecc_addr),
        .ecc_chan (ecc_chan),
        .ecc_syn  (ecc_syn),
        .state_q  (log_state),
        .addr_q   (log_addr),
        .chan_q   (log_chan),
        .syn_q    (log_syn)
    );

    errlog_regport #(.AW(LOG_AW), .SYN_W(SYN_W)) u_regport (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .status   (status_q),
        .log_addr (log_addr),
        .log_chan (log_chan),
        .log_syn  (log_syn),
        .cmd_q    (cmd_q),
        .clr_vec  (clr_vec),
        .rd_data  (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            serr <= 1'b0;
        end else begin
            serr <= |(status_q & cmd_q);
        end
    end

endmodule

// File: rtl/errlog_chk.sv
module errlog_chk
    import errlog_pkg::*;
#(
    parameter int SYN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_ce,
    input logic              ev_ue,
    input logic [SYN_W-1:0]  ecc_syn,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [ST_W-1:0]   wr_data,
    input logic [ST_W-1:0]   status,
    input logic [ST_W-1:0]   cmd,
    input log_state_t        log_state,
    input logic [LOG_AW-1:0] log_addr,
    input logic [SYN_W-1:0]  syn,
    input logic              serr
);

    // R3
    ce_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ce |=> status[BIT_CE]);

    // R2
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_STS && wr_data[BIT_UE] && !ev_ue)
        |=> !status[BIT_UE]);

    // R7
    ce_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ce && !ev_ue && status[BIT_CE:0] != 2'b00) |=> $stable(syn));

    // R8
    ue_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ue && !status[BIT_UE]) |=> (syn == $past(ecc_syn)));

    // R8
    log_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((log_state == LOG_UE) == status[BIT_UE]) &&
        ((log_state == LOG_NONE) == (status[BIT_UE:0] == 2'b00)));

    // R11
    serr_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & cmd) != '0) |=> serr);

    // R12
    ptr_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == OFS_PTR && !ev_ce && !ev_ue) |=> $stable(log_addr));

endmodule

bind errlog_top errlog_chk #(.SYN_W(SYN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_ce     (ev_ce),
    .ev_ue     (ev_ue),
    .ecc_syn   (ecc_syn),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .status    (status_q),
    .cmd       (cmd_q),
    .log_state (log_state),
    .log_addr  (log_addr),
    .syn       (log_syn),
    .serr      (serr)
);

// File: tb/tb_errlog_top.sv
`timescale 1ns/1ps
module tb_errlog_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_ce = 1'b0, ev_ue = 1'b0, ev_refto = 1'b0;
    logic        ev_lock = 1'b0, ev_therm = 1'b0;
    logic [25:0] ecc_addr = '0;
    logic        ecc_chan = 1'b0;
    logic [7:0]  ecc_syn = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        serr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    errlog_top dut (
        .clk(clk), .rst_n(rst_n),
        .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_refto(ev_refto),
        .ev_lock(ev_lock), .ev_therm(ev_therm),
        .ecc_addr(ecc_addr), .ecc_chan(ecc_chan), .ecc_syn(ecc_syn),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .serr(serr)
    );

    // event field order: {therm, lock, refto, ue, ce}
    typedef struct packed {
        logic [4:0]  ev;
        logic [25:0] a;
        logic        ch;
        logic [7:0]  sy;
        logic [15:0] est;
        logic [25:0] ea;
        logic        ech;
        logic [7:0]  esy;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{5'b00001, 26'h2ABCDE1, 1'b0, 8'h11, 16'h0001, 26'h2ABCDE1, 1'b0, 8'h11},
        '{5'b00001, 26'h0123456, 1'b1, 8'h22, 16'h0001, 26'h2ABCDE1, 1'b0, 8'h11},
        '{5'b00010, 26'h1555555, 1'b1, 8'h33, 16'h0003, 26'h1555555, 1'b1, 8'h33},
        '{5'b00010, 26'h3FFFFFF, 1'b0, 8'h44, 16'h0003, 26'h1555555, 1'b1, 8'h33},
        '{5'b00100, 26'h0000000, 1'b0, 8'h00, 16'h0103, 26'h1555555, 1'b1, 8'h33},
        '{5'b11000, 26'h0000000, 1'b0, 8'h00, 16'h0B03, 26'h1555555, 1'b1, 8'h33}
    };

    function automatic logic [31:0] ptr_of(logic [25:0] a, logic c);
        return {a[24:0], 6'b000000, c};
    endfunction

    function automatic logic [31:0] ext_of(logic [25:0] a);
        return {31'b0, a[25]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic chkreg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic pulse(input logic [4:0] e, input logic [25:0] a,
                         input logic c, input logic [7:0] s);
        @(negedge clk);
        {ev_therm, ev_lock, ev_refto, ev_ue, ev_ce} = e;
        ecc_addr = a;
        ecc_chan = c;
        ecc_syn  = s;
        @(negedge clk);
        {ev_therm, ev_lock, ev_refto, ev_ue, ev_ce} = 5'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13 reset state
        chkreg("R13 status", 3'd0, 32'h0);
        chkreg("R13 cmd", 3'd1, 32'h0);
        chkreg("R13 ptr", 3'd2, 32'h0);
        chkreg("R13 ext", 3'd3, 32'h0);
        chkreg("R13 syn", 3'd4, 32'h0);
        chk("R13 serr", {31'b0, serr}, 32'h0);

        // table: R1 layout, R4/R5/R6 format, R7/R8 capture rules, R11 with cmd 0
        for (int i = 0; i < 6; i++) begin
            pulse(TBL[i].ev, TBL[i].a, TBL[i].ch, TBL[i].sy);
            chkreg($sformatf("R1 status vec%0d", i), 3'd0, {16'b0, TBL[i].est});
            chkreg($sformatf("R4 R7 R8 ptr vec%0d", i), 3'd2, ptr_of(TBL[i].ea, TBL[i].ech));
            chkreg($sformatf("R5 ext vec%0d", i), 3'd3, ext_of(TBL[i].ea));
            chkreg($sformatf("R6 syn vec%0d", i), 3'd4, {24'b0, TBL[i].esy});
            @(negedge clk);
            chk($sformatf("R11 serr cmd0 vec%0d", i), {31'b0, serr}, 32'h0);
        end

        // R12 log registers ignore writes
        wr(3'd2, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        wr(3'd4, 16'hFFFF);
        chkreg("R12 ptr", 3'd2, ptr_of(26'h1555555, 1'b1));
        chkreg("R12 ext", 3'd3, ext_of(26'h1555555));
        chkreg("R12 syn", 3'd4, 32'h33);
        chkreg("R12 status", 3'd0, 32'h0B03);

        // R1 unmapped offsets
        chkreg("R1 ofs5", 3'd5, 32'h0);
        chkreg("R1 ofs7", 3'd7, 32'h0);

        // R2 writing zeros, then clearing only the uncorrectable flag
        wr(3'd0, 16'h0000);
        chkreg("R2 write0", 3'd0, 32'h0B03);
        wr(3'd0, 16'h0002);
        chkreg("R2 clear ue", 3'd0, 32'h0B01);

        // R8 new uncorrectable captures while only a correctable flag is set
        pulse(5'b00010, 26'h0000080, 1'b0, 8'h55);
        chkreg("R8 status", 3'd0, 32'h0B03);
        chkreg("R8 ptr", 3'd2, ptr_of(26'h0000080, 1'b0));
        chkreg("R8 syn", 3'd4, 32'h55);

        // R7 correctable does not replace an uncorrectable log
        pulse(5'b00001, 26'h0AAAAAA, 1'b1, 8'h99);
        chkreg("R7 syn kept", 3'd4, 32'h55);
        chkreg("R7 ptr kept", 3'd2, ptr_of(26'h0000080, 1'b0));

        // R2 clear everything (reserved bits written as 1 too)
        wr(3'd0, 16'hFFFF);
        chkreg("R2 clear all", 3'd0, 32'h0);

        // R7 correctable captures into an empty log
        pulse(5'b00001, 26'h0F0F0F0, 1'b1, 8'h66);
        chkreg("R7 status", 3'd0, 32'h0001);
        chkreg("R7 ptr", 3'd2, ptr_of(26'h0F0F0F0, 1'b1));
        chkreg("R7 syn", 3'd4, 32'h66);

        // R9 both ECC errors in one cycle
        wr(3'd0, 16'h0001);
        pulse(5'b00011, 26'h1234567, 1'b1, 8'h77);
        chkreg("R9 status", 3'd0, 32'h0003);
        chkreg("R9 ptr", 3'd2, ptr_of(26'h1234567, 1'b1));
        chkreg("R9 ext", 3'd3, ext_of(26'h1234567));
        chkreg("R9 syn", 3'd4, 32'h77);
        wr(3'd0, 16'hFFFF);

        // R10 command register masking
        wr(3'd1, 16'hFFFF);
        chkreg("R10 cmd all", 3'd1, 32'h0B03);
        wr(3'd1, 16'h0100);
        chkreg("R10 cmd rto", 3'd1, 32'h0100);

        // R11 unenabled source does not signal
        pulse(5'b00001, 26'h0000001, 1'b0, 8'h01);
        @(negedge clk);
        chk("R11 ce masked", {31'b0, serr}, 32'h0);
        wr(3'd0, 16'hFFFF);

        // R11 enabled source signals one cycle after the flag
        pulse(5'b00100, 26'h0, 1'b0, 8'h00);
        chk("R11 serr lag", {31'b0, serr}, 32'h0);
        @(negedge clk);
        chk("R11 serr high", {31'b0, serr}, 32'h1);
        wr(3'd0, 16'h0100);
        @(negedge clk);
        chk("R11 serr low", {31'b0, serr}, 32'h0);

        // R3 event and clear of the same flag together
        @(negedge clk);
        ev_refto = 1'b1;
        wr_en    = 1'b1;
        wr_addr  = 3'd0;
        wr_data  = 16'h0100;
        @(negedge clk);
        ev_refto = 1'b0;
        wr_en    = 1'b0;
        chkreg("R3 event wins", 3'd0, 32'h0100);

        // R13 reset again with content present
        pulse(5'b00010, 26'h3000001, 1'b1, 8'hAB);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chkreg("R13 status after", 3'd0, 32'h0);
        chkreg("R13 cmd after", 3'd1, 32'h0);
        chkreg("R13 ptr after", 3'd2, 32'h0);
        chkreg("R13 syn after", 3'd4, 32'h0);
        chk("R13 serr after", {31'b0, serr}, 32'h0);

        finish_run();
    end

endmodule